// File: doc/BRIEF.md
# Ring Oscillator Cell-Mode Step Controller

This block turns a serial stream of single-cycle raise and lower strobes into the control word of a ring oscillator built from N identical tunable delay cells. Each cell takes one control bit: 1 puts the cell in fast mode and 0 puts it in slow mode. The oscillator frequency depends only on how many cells are fast. It does not depend on which cells they are.

Because position does not matter, the block does not shift a thermometer code. A raise strobe makes the lowest-index slow cell fast. A lower strobe makes the lowest-index fast cell slow. Each change is applied at the clock edge that samples the strobe, so the block accepts a strobe on every cycle without stalling. A strobe that would push the word past either end is dropped. Two level flags show that the word is at full scale or at zero. A count output gives the number of fast cells. After reset, half the cells are fast, so the oscillator starts in the middle of its range.

Top module: `dcw_cell_mode_ctrl`

## Requirements
- R1: While reset is high and at the first edge after it, `mode_o` has bits 0 to N/2-1 set and all other bits clear. For N=4 this is 4'b0011, and `fast_cnt_o` is then 2.
- R2: When `up_i`=1, `dn_i`=0 and at least one bit is clear, the next edge sets the lowest-index clear bit of `mode_o` and changes no other bit.
- R3: When `dn_i`=1, `up_i`=0 and at least one bit is set, the next edge clears the lowest-index set bit of `mode_o` and changes no other bit.
- R4: When `up_i`=1 and `dn_i`=0 while all bits are set, the raise is ignored and `mode_o` stays unchanged.
- R5: When `dn_i`=1 and `up_i`=0 while all bits are clear, the lower is ignored and `mode_o` stays unchanged.
- R6: When `up_i` and `dn_i` are both 1 in the same cycle, `mode_o` stays unchanged.
- R7: When neither strobe is high, `mode_o` stays unchanged.
- R8: In every cycle, `fast_cnt_o` equals the number of 1 bits in `mode_o`.
- R9: `sat_hi_o` is 1 exactly when all N bits of `mode_o` are 1. `sat_lo_o` is 1 exactly when all bits are 0.
- R10: Strobes on consecutive cycles are each applied. For example, N back-to-back raises from zero reach full scale in N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_i | input | 1 | Raise strobe: make one more cell fast |
| dn_i | input | 1 | Lower strobe: make one fast cell slow |
| mode_o | output | N | Cell mode word, 1 = fast |
| fast_cnt_o | output | $clog2(N+1) | Number of fast cells |
| sat_hi_o | output | 1 | All cells fast |
| sat_lo_o | output | 1 | All cells slow |

## Verification
The mode word is the only state, and it drives every output directly. A wrong bit therefore shows on `mode_o` at the edge that writes it, with no delay. A fault that picks the wrong cell shows as an unexpected bit pattern even when the count is correct. A fault in the stepping or the limits shows as a count that is off by one, or as a flag that disagrees with the word. The bench drives a long pseudo-random mix of all four strobe combinations, plus runs that push into both limits. It compares every output after every edge against a bit-level model, so a fault appears in the first cycle it affects.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

    // Decoded intent of one cycle of strobes
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_RAISE = 2'd1,
        CMD_LOWER = 2'd2,
        CMD_CLASH = 2'd3
    } step_cmd_e;

    function automatic step_cmd_e decode_step(input logic up, input logic dn);
        step_cmd_e c;
        case ({up, dn})
            2'b10:   c = CMD_RAISE;
            2'b01:   c = CMD_LOWER;
            2'b11:   c = CMD_CLASH;
            default: c = CMD_IDLE;
        endcase
        return c;
    endfunction

    // Next-state bookkeeping passed between stages
    typedef struct packed {
        logic apply_raise;
        logic apply_lower;
    } step_act_s;

endpackage

// File: rtl/dcw_step_decode.sv
module dcw_step_decode
    import dcw_pkg::*;
(
    input  logic      up_i,
    input  logic      dn_i,
    input  logic      full_i,
    input  logic      empty_i,
    output step_act_s act_o
);
    step_cmd_e cmd;

    always_comb begin
        cmd = decode_step(up_i, dn_i);
        act_o = '0;
        unique case (cmd)
            CMD_RAISE: act_o.apply_raise = ~full_i;
            CMD_LOWER: act_o.apply_lower = ~empty_i;
            default:   act_o = '0;
        endcase
    end

    // R6: a clash or idle cycle never produces an action
    always_comb begin
        if (up_i == dn_i) begin
            a_idle_no_act_r6: assert (act_o == '0);
        end
    end
endmodule

// File: rtl/dcw_pick_lowest.sv
module dcw_pick_lowest #(
    parameter int N = 4
) (
    input  logic [N-1:0] vec_i,
    output logic [N-1:0] grant_o
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign seen[i+1]  = seen[i] | vec_i[i];
        assign grant_o[i] = vec_i[i] & ~seen[i];
    end

    // R2/R3: at most one cell is chosen, and only when a candidate exists
    always_comb begin
        a_grant_onehot_r2: assert ($onehot0(grant_o));
        a_grant_present_r3: assert ((grant_o != '0) == (vec_i != '0));
    end
endmodule

// File: rtl/dcw_popcount.sv
module dcw_popcount #(
    parameter int N  = 4,
    localparam int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < N; i++) begin
            cnt_o = cnt_o + CW'(vec_i[i]);
        end
    end
endmodule

// File: rtl/dcw_cell_mode_ctrl.sv
module dcw_cell_mode_ctrl
    import dcw_pkg::*;
#(
    parameter int N  = 4,
    localparam int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          up_i,
    input  logic          dn_i,
    output logic [N-1:0]  mode_o,
    output logic [CW-1:0] fast_cnt_o,
    output logic          sat_hi_o,
    output logic          sat_lo_o
);
    localparam int          HALF      = N / 2;
    localparam logic [N-1:0] MODE_INIT = {N{1'b1}} >> (N - HALF);

    logic [N-1:0] mode_q, mode_d;
    logic [N-1:0] raise_pick, lower_pick;
    step_act_s    act;

    assign sat_hi_o = &mode_q;
    assign sat_lo_o = ~|mode_q;

    dcw_step_decode u_dec (
        .up_i    (up_i),
        .dn_i    (dn_i),
        .full_i  (sat_hi_o),
        .empty_i (sat_lo_o),
        .act_o   (act)
    );

    // lowest slow cell and lowest fast cell
    dcw_pick_lowest #(.N(N)) u_pick_slow (
        .vec_i   (~mode_q),
        .grant_o (raise_pick)
    );

    dcw_pick_lowest #(.N(N)) u_pick_fast (
        .vec_i   (mode_q),
        .grant_o (lower_pick)
    );

    always_comb begin
        mode_d = mode_q;
        if (act.apply_raise) mode_d = mode_q | raise_pick;
        else if (act.apply_lower) mode_d = mode_q & ~lower_pick;
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_INIT;
        else     mode_q <= mode_d;
    end

    assign mode_o = mode_q;

    dcw_popcount #(.N(N)) u_cnt (
        .vec_i (mode_q),
        .cnt_o (fast_cnt_o)
    );

    // ---------------- assertions ----------------
    p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
        (up_i && !dn_i && !sat_hi_o) |=> (fast_cnt_o == $past(fast_cnt_o) + CW'(1)));

    p_step_dn_r3: assert property (@(posedge clk) disable iff (rst)
        (dn_i && !up_i && !sat_lo_o) |=> (fast_cnt_o == $past(fast_cnt_o) - CW'(1)));

    p_single_cell_r10: assert property (@(posedge clk) disable iff (rst)
        (up_i ^ dn_i) |=> $onehot0(mode_o ^ $past(mode_o)));

    p_full_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (up_i && !dn_i && sat_hi_o) |=> $stable(mode_o));

    p_empty_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (dn_i && !up_i && sat_lo_o) |=> $stable(mode_o));

    p_clash_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (up_i && dn_i) |=> $stable(mode_o));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!up_i && !dn_i) |=> $stable(mode_o));

    p_count_match_r8: assert property (@(posedge clk) disable iff (rst)
        fast_cnt_o == CW'($countones(mode_o)));

    p_flags_r9: assert property (@(posedge clk) disable iff (rst)
        (sat_hi_o == (fast_cnt_o == CW'(N))) && (sat_lo_o == (fast_cnt_o == '0)));
endmodule

// File: tb/dcw_cell_mode_ctrl_tb.sv
`timescale 1ns/1ps
module dcw_cell_mode_ctrl_tb;
    localparam int N  = 4;
    localparam int CW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          up_i = 1'b0;
    logic          dn_i = 1'b0;
    logic [N-1:0]  mode_o;
    logic [CW-1:0] fast_cnt_o;
    logic          sat_hi_o, sat_lo_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [N-1:0] exp_mode;
    logic [15:0]  lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    dcw_cell_mode_ctrl #(.N(N)) u_dut (
        .clk(clk), .rst(rst), .up_i(up_i), .dn_i(dn_i),
        .mode_o(mode_o), .fast_cnt_o(fast_cnt_o),
        .sat_hi_o(sat_hi_o), .sat_lo_o(sat_lo_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int ones(input logic [N-1:0] v);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(v[i]);
        return c;
    endfunction

    // model from requirements R2..R7
    function automatic logic [N-1:0] model(input logic [N-1:0] m, input logic u, input logic d);
        logic [N-1:0] r = m;
        if (u && !d) begin
            for (int i = 0; i < N; i++) if (!m[i]) begin r[i] = 1'b1; break; end
        end else if (d && !u) begin
            for (int i = 0; i < N; i++) if (m[i]) begin r[i] = 1'b0; break; end
        end
        return r;
    endfunction

    task automatic check_all(input string tag);
        check({tag, " mode"}, int'(mode_o), int'(exp_mode));
        check("R8 count", int'(fast_cnt_o), ones(mode_o));
        check("R9 sat_hi", int'(sat_hi_o), int'(exp_mode == {N{1'b1}}));
        check("R9 sat_lo", int'(sat_lo_o), int'(exp_mode == '0));
    endtask

    task automatic step(input logic u, input logic d, input string tag);
        @(negedge clk);
        up_i = u; dn_i = d;
        exp_mode = model(exp_mode, u, d);
        @(posedge clk);
        #1;
        check_all(tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        exp_mode = 4'b0011;
        check("R1 reset mode", int'(mode_o), 3);
        check("R1 reset count", int'(fast_cnt_o), 2);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check_all("R1 after reset");

        step(1'b0, 1'b0, "R7 idle");
        step(1'b1, 1'b1, "R6 clash");
        step(1'b1, 1'b0, "R2 raise");          // 0111
        step(1'b0, 1'b1, "R3 lower");          // 0110
        step(1'b1, 1'b0, "R2 raise low gap");  // 0111
        // back-to-back raises into and past full scale
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, "R10 raise burst");
        check("R10 full after burst", int'(mode_o), 15);
        step(1'b1, 1'b0, "R4 raise at full");
        step(1'b1, 1'b1, "R6 clash at full");
        // back-to-back lowers to zero and below
        for (int k = 0; k < N; k++) step(1'b0, 1'b1, "R10 lower burst");
        check("R10 empty after burst", int'(mode_o), 0);
        step(1'b0, 1'b1, "R5 lower at empty");
        step(1'b0, 1'b1, "R5 lower at empty again");
        for (int k = 0; k < N; k++) step(1'b1, 1'b0, "R10 raise from empty");
        check("R10 full from empty", int'(mode_o), 15);

        // pseudo-random sweep of all strobe combinations
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], lfsr[1] & ~lfsr[2] | (lfsr[3] & lfsr[0]), "R2/R3 sweep");
        end

        // reset mid-run returns to mid-range
        @(negedge clk); rst = 1'b1; up_i = 1'b0; dn_i = 1'b0;
        @(posedge clk); #1;
        exp_mode = 4'b0011;
        check_all("R1 re-reset");
        @(negedge clk); rst = 1'b0;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule